// File: doc/BRIEF.md
# Two-Level Page Table Walker

The walker resolves a 32-bit virtual address that has missed in the translation cache. It performs a hardware walk of a two-level page table in memory. The walk starts from a root register that holds the page number of the directory. The walker first fetches a directory entry, which names the page holding the second-level table. It then fetches the table entry, which names the physical page. If either entry is marked invalid, the walk ends with a fault, and the response reports which level stopped it.

The translation cache hands the walker one address at a time over a ready/valid request. It receives a single-cycle response that carries either the translated address with its permission bits, or a fault. The cache installs a successful result and retries the access that missed.

Memory is reached through a read port. Each request is held until the memory accepts it, and the word comes back on a separate response strobe. Only one walk is in flight at a time. The root register can be written only while the walker is idle.

Top module: `pt_walker`

## Requirements
- R1: After reset, `req_ready` is 1, while `resp_valid` and `mem_req_valid` are both 0.
- R2: The cycle after a request is accepted, the walker issues its first memory read at address `{root_page, 12'h000} + vaddr[31:22]*4`.
- R3: An entry is valid when its bit 0 is 1. If the directory entry has bit 0 equal to 0, the walk ends with `resp_fault`=1 and `resp_level`=0, and no second read is made.
- R4: After a valid directory entry, the second read goes to `{dir_entry[31:12], 12'h000} + vaddr[21:12]*4`.
- R5: If the table entry has bit 0 equal to 0, the walk ends with `resp_fault`=1 and `resp_level`=1.
- R6: A successful walk returns `resp_fault`=0 and `resp_paddr = {pte[31:12], vaddr[11:0]}`, so the low 12 offset bits pass through unchanged. It also returns `resp_perm = pte[3:1]`, where bit 3 of the entry is user, bit 2 is write and bit 1 is read.
- R7: `resp_valid` is high for exactly one cycle, after which the walker is idle again. `req_ready` is high only while idle. A request presented while a walk is busy is ignored, and it causes neither a read nor a response.
- R8: A write to the root register takes effect only while the walker is idle. A write during a walk is ignored.
- R9: While `mem_req_ready` is low, a pending memory request keeps `mem_req_valid` high and holds `mem_req_addr` unchanged.
- R10: With a memory that is always ready and answers in the next cycle, the response appears at different points depending on the outcome:
  - for a completed walk or a table-level fault, 4 cycles after the accepting edge;
  - for a directory-level fault, 2 cycles after the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| root_we | input | 1 | Root page write strobe, honoured only while idle |
| root_page | input | 20 | Page number of the directory |
| req_valid | input | 1 | Walk request from the translation cache |
| req_ready | output | 1 | Walker idle and able to accept a request |
| req_vaddr | input | 32 | Virtual address to translate |
| resp_valid | output | 1 | One-cycle walk result strobe |
| resp_fault | output | 1 | Result is a fault |
| resp_level | output | 1 | Fault level: 0 directory, 1 table |
| resp_paddr | output | 32 | Physical address (page from entry, offset from request) |
| resp_perm | output | 3 | Permissions {user, write, read} |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 32 | Byte address of the entry |
| mem_resp_valid | input | 1 | Read data strobe |
| mem_resp_data | input | 32 | Entry word read from memory |

## Verification
The bench builds the walker with its default geometry: a 32-bit address, 10 directory bits, 10 table bits and a 12-bit offset. With this geometry a small behavioural memory holds the directory and two tables, and the bench can reach both index extremes (0 and 1023) at each level, as well as the all-zero and all-one offsets.

The memory model answers one cycle after a read is accepted, which exposes the exact 4-cycle and 2-cycle latencies. A stall switch holds off acceptance so that the bench can check that a pending request is held. Further directed walks repoint the root while busy and while idle, and present a second request during a walk.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;
  typedef enum logic [2:0] {
    WK_IDLE,
    WK_RD_DIR,
    WK_WT_DIR,
    WK_RD_PTE,
    WK_WT_PTE,
    WK_DONE,
    WK_FAULT
  } walk_state_e;
endpackage

// File: rtl/pt_idx_split.sv
module pt_idx_split #(
  parameter int VA_W      = 32,
  parameter int PAGE_BITS = 12,
  parameter int DIR_BITS  = 10,
  parameter int TBL_BITS  = 10
) (
  input  logic [VA_W-1:0]      va,
  output logic [DIR_BITS-1:0]  dir_idx,
  output logic [TBL_BITS-1:0]  tbl_idx,
  output logic [PAGE_BITS-1:0] offset
);
  localparam int TBL_LO = PAGE_BITS;
  localparam int DIR_LO = PAGE_BITS + TBL_BITS;

  assign offset  = va[PAGE_BITS-1:0];
  assign tbl_idx = va[TBL_LO+TBL_BITS-1:TBL_LO];
  assign dir_idx = va[DIR_LO+DIR_BITS-1:DIR_LO];
endmodule

// File: rtl/pt_entry_addr.sv
module pt_entry_addr #(
  parameter int PA_W      = 32,
  parameter int PAGE_BITS = 12,
  parameter int IDX_W     = 10
) (
  input  logic [PA_W-PAGE_BITS-1:0] base_page,
  input  logic [IDX_W-1:0]          idx,
  output logic [PA_W-1:0]           addr
);
  localparam int PPN_W     = PA_W - PAGE_BITS;
  localparam int ENT_SHIFT = $clog2(PA_W / 8);

  // Byte address of slot idx in the table that starts at page pg.
  function automatic logic [PA_W-1:0] slot_addr(input logic [PPN_W-1:0] pg,
                                                input logic [IDX_W-1:0] ix);
    logic [PA_W-1:0] wide_ix;
    wide_ix = PA_W'(ix);
    return {pg, {PAGE_BITS{1'b0}}} + (wide_ix << ENT_SHIFT);
  endfunction

  assign addr = slot_addr(base_page, idx);
endmodule

// File: rtl/pt_entry_decode.sv
module pt_entry_decode #(
  parameter int PA_W      = 32,
  parameter int PAGE_BITS = 12
) (
  input  logic [PA_W-1:0]           entry,
  output logic                      valid,
  output logic [PA_W-PAGE_BITS-1:0] page,
  output logic [2:0]                perm
);
  logic unused_rsvd;

  assign valid       = entry[0];
  assign perm        = entry[3:1];
  assign page        = entry[PA_W-1:PAGE_BITS];
  assign unused_rsvd = ^entry[PAGE_BITS-1:4];
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walker_pkg::*;
#(
  parameter int VA_W      = 32,
  parameter int PA_W      = 32,
  parameter int PAGE_BITS = 12,
  parameter int DIR_BITS  = 10,
  parameter int TBL_BITS  = 10
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      root_we,
  input  logic [PA_W-PAGE_BITS-1:0] root_page,
  input  logic                      req_valid,
  output logic                      req_ready,
  input  logic [VA_W-1:0]           req_vaddr,
  output logic                      resp_valid,
  output logic                      resp_fault,
  output logic                      resp_level,
  output logic [PA_W-1:0]           resp_paddr,
  output logic [2:0]                resp_perm,
  output logic                      mem_req_valid,
  input  logic                      mem_req_ready,
  output logic [PA_W-1:0]           mem_req_addr,
  input  logic                      mem_resp_valid,
  input  logic [PA_W-1:0]           mem_resp_data
);
  localparam int PPN_W = PA_W - PAGE_BITS;
  localparam int IDX_W = (DIR_BITS > TBL_BITS) ? DIR_BITS : TBL_BITS;

  walk_state_e          state_q, state_d;
  logic [VA_W-1:0]      va_q;
  logic [PPN_W-1:0]     root_q;
  logic [PPN_W-1:0]     next_q;
  logic [2:0]           perm_q;
  logic                 level_q;

  logic [DIR_BITS-1:0]  dir_idx;
  logic [TBL_BITS-1:0]  tbl_idx;
  logic [PAGE_BITS-1:0] va_off;
  logic [PPN_W-1:0]     sel_page;
  logic [IDX_W-1:0]     sel_idx;
  logic                 ent_valid;
  logic [PPN_W-1:0]     ent_page;
  logic [2:0]           ent_perm;

  // Named events used by the logic and the assertions
  logic idle, req_fire, root_take, dir_arrive, pte_arrive;
  assign idle       = (state_q == WK_IDLE);
  assign req_fire   = req_valid && idle;
  assign root_take  = root_we && idle;
  assign dir_arrive = mem_resp_valid && (state_q == WK_WT_DIR);
  assign pte_arrive = mem_resp_valid && (state_q == WK_WT_PTE);

  pt_idx_split #(.VA_W(VA_W), .PAGE_BITS(PAGE_BITS), .DIR_BITS(DIR_BITS), .TBL_BITS(TBL_BITS))
    u_split (.va(va_q), .dir_idx(dir_idx), .tbl_idx(tbl_idx), .offset(va_off));

  assign sel_page = (state_q == WK_RD_DIR) ? root_q : next_q;
  assign sel_idx  = (state_q == WK_RD_DIR) ? IDX_W'(dir_idx) : IDX_W'(tbl_idx);

  pt_entry_addr #(.PA_W(PA_W), .PAGE_BITS(PAGE_BITS), .IDX_W(IDX_W))
    u_addr (.base_page(sel_page), .idx(sel_idx), .addr(mem_req_addr));

  pt_entry_decode #(.PA_W(PA_W), .PAGE_BITS(PAGE_BITS))
    u_dec (.entry(mem_resp_data), .valid(ent_valid), .page(ent_page), .perm(ent_perm));

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      WK_IDLE:   if (req_valid) state_d = WK_RD_DIR;
      WK_RD_DIR: if (mem_req_ready) state_d = WK_WT_DIR;
      WK_WT_DIR: if (mem_resp_valid) state_d = ent_valid ? WK_RD_PTE : WK_FAULT;
      WK_RD_PTE: if (mem_req_ready) state_d = WK_WT_PTE;
      WK_WT_PTE: if (mem_resp_valid) state_d = ent_valid ? WK_DONE : WK_FAULT;
      WK_DONE:   state_d = WK_IDLE;
      WK_FAULT:  state_d = WK_IDLE;
      default:   state_d = WK_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= WK_IDLE;
      va_q    <= '0;
      root_q  <= '0;
      next_q  <= '0;
      perm_q  <= '0;
      level_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (root_take) root_q <= root_page;
      if (req_fire) begin
        va_q    <= req_vaddr;
        level_q <= 1'b0;
      end
      if (dir_arrive && ent_valid) begin
        next_q  <= ent_page;
        level_q <= 1'b1;
      end
      if (pte_arrive && ent_valid) begin
        next_q <= ent_page;
        perm_q <= ent_perm;
      end
    end
  end

  assign req_ready     = idle;
  assign mem_req_valid = (state_q == WK_RD_DIR) || (state_q == WK_RD_PTE);
  assign resp_valid    = (state_q == WK_DONE) || (state_q == WK_FAULT);
  assign resp_fault    = (state_q == WK_FAULT);
  assign resp_level    = level_q;
  assign resp_paddr    = {next_q, va_off};
  assign resp_perm     = perm_q;

  // R9
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  // R7
  resp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |=> !resp_valid && req_ready);

  // R7
  busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !req_ready);

  // R8
  root_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    root_we && !req_ready |=> $stable(root_q));

  // R2
  first_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> mem_req_valid);

  // R3
  dir_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dir_arrive && !ent_valid |=> resp_valid && resp_fault && !resp_level);
endmodule

// File: tb/test_pt_walker.sv
`timescale 1ns/100ps
module test_pt_walker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        root_we = 1'b0;
  logic [19:0] root_page = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic        resp_valid, resp_fault, resp_level;
  logic [31:0] resp_paddr;
  logic [2:0]  resp_perm;
  logic        mem_req_valid;
  logic        mem_req_ready;
  logic [31:0] mem_req_addr;
  logic        mem_resp_valid = 1'b0;
  logic [31:0] mem_resp_data = '0;
  logic        stall_mem = 1'b0;

  int n_tests = 0;
  int n_fail  = 0;

  always #2.5 clk = ~clk;

  pt_walker i_pt_walker (
    .clk(clk), .rst_n(rst_n), .root_we(root_we), .root_page(root_page),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .resp_valid(resp_valid), .resp_fault(resp_fault), .resp_level(resp_level),
    .resp_paddr(resp_paddr), .resp_perm(resp_perm),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_resp_valid(mem_resp_valid),
    .mem_resp_data(mem_resp_data)
  );

  // Behavioural memory: 16 KB of words, reads outside return zero
  logic [31:0] mem [0:4095];
  logic [31:0] rd_log [0:63];
  int rd_cnt = 0;
  int resp_cnt = 0;

  assign mem_req_ready = !stall_mem;

  function automatic logic [31:0] mem_read(input logic [31:0] a);
    return (a < 32'h4000) ? mem[a[13:2]] : 32'h0;
  endfunction

  always @(posedge clk) begin
    mem_resp_valid <= 1'b0;
    if (mem_req_valid && mem_req_ready) begin
      mem_resp_valid <= 1'b1;
      mem_resp_data  <= mem_read(mem_req_addr);
      rd_log[rd_cnt[5:0]] <= mem_req_addr;
      rd_cnt <= rd_cnt + 1;
    end
    if (resp_valid) resp_cnt <= resp_cnt + 1;
  end

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  // Entry word: {page, 8'h0, perm[2:0], valid}
  function automatic logic [31:0] mk_ent(input logic [19:0] pg, input logic [2:0] pm,
                                         input logic v);
    return {pg, 8'h00, pm, v};
  endfunction

  typedef struct packed {
    logic [31:0] va;
    logic        fault;
    logic        lvl;
    logic [31:0] paddr;
    logic [2:0]  perm;
    logic [31:0] a0;
    logic [31:0] a1;
    logic [31:0] cyc;
  } vec_t;

  localparam int NV = 5;
  localparam vec_t VECS [NV] = '{
    '{32'h0000_0123, 1'b0, 1'b0, 32'hABCD_E123, 3'b011, 32'h1000, 32'h2000, 32'd4},
    '{32'h003F_FFFF, 1'b0, 1'b0, 32'h1234_5FFF, 3'b101, 32'h1000, 32'h2FFC, 32'd4},
    '{32'hFFE0_0000, 1'b0, 1'b0, 32'hFFFF_F000, 3'b111, 32'h1FFC, 32'h3800, 32'd4},
    '{32'h0140_0456, 1'b1, 1'b0, 32'h0,         3'b000, 32'h1014, 32'h0,    32'd2},
    '{32'h0000_7ABC, 1'b1, 1'b1, 32'h0,         3'b000, 32'h1000, 32'h201C, 32'd4}
  };

  logic        w_fault, w_lvl;
  logic [31:0] w_pa;
  logic [2:0]  w_pm;
  int          w_cyc, w_nrd, w_first;

  task automatic run_walk(input logic [31:0] va);
    @(negedge clk);
    w_first   = rd_cnt;
    req_valid = 1'b1;
    req_vaddr = va;
    @(negedge clk);
    req_valid = 1'b0;
    w_cyc = 0;
    while (!resp_valid && w_cyc < 60) begin
      @(negedge clk);
      w_cyc++;
    end
    w_fault = resp_fault;
    w_lvl   = resp_level;
    w_pa    = resp_paddr;
    w_pm    = resp_perm;
    @(negedge clk);
    w_nrd = rd_cnt - w_first;
    chk("R7", "strobe drops", {31'b0, resp_valid}, 32'd0);
    chk("R7", "idle after result", {31'b0, req_ready}, 32'd1);
  endtask

  task automatic set_root(input logic [19:0] pg);
    @(negedge clk);
    root_we   = 1'b1;
    root_page = pg;
    @(negedge clk);
    root_we = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got hang expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int r0, p0;
    for (int i = 0; i < 4096; i++) mem[i] = 32'h0;
    mem[(32'h1000 >> 2)]        = mk_ent(20'h00002, 3'b000, 1'b1);
    mem[(32'h1FFC >> 2)]        = mk_ent(20'h00003, 3'b000, 1'b1);
    mem[(32'h2000 >> 2)]        = mk_ent(20'hABCDE, 3'b011, 1'b1);
    mem[(32'h2FFC >> 2)]        = mk_ent(20'h12345, 3'b101, 1'b1);
    mem[(32'h3800 >> 2)]        = mk_ent(20'hFFFFF, 3'b111, 1'b1);

    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "req_ready", {31'b0, req_ready}, 32'd1);
    chk("R1", "resp_valid", {31'b0, resp_valid}, 32'd0);
    chk("R1", "mem_req_valid", {31'b0, mem_req_valid}, 32'd0);
    rst_n = 1'b1;
    set_root(20'h00001);

    // Vector table: R2 R3 R4 R5 R6 R10
    for (int v = 0; v < NV; v++) begin
      run_walk(VECS[v].va);
      chk("R3/R5", "fault", {31'b0, w_fault}, {31'b0, VECS[v].fault});
      chk("R2", "directory addr", rd_log[w_first[5:0]], VECS[v].a0);
      chk("R10", "latency", w_cyc, VECS[v].cyc);
      if (VECS[v].fault && !VECS[v].lvl) begin
        chk("R3", "level", {31'b0, w_lvl}, 32'd0);
        chk("R3", "read count", w_nrd, 32'd1);
      end else begin
        chk("R4", "table addr", rd_log[(w_first + 1) % 64], VECS[v].a1);
        chk("R4", "read count", w_nrd, 32'd2);
        if (VECS[v].fault) chk("R5", "level", {31'b0, w_lvl}, 32'd1);
        else begin
          chk("R6", "paddr", w_pa, VECS[v].paddr);
          chk("R6", "perm", {29'b0, w_pm}, {29'b0, VECS[v].perm});
        end
      end
    end

    // R9: stalled memory holds the request
    stall_mem = 1'b1;
    fork
      run_walk(32'h0000_0123);
      begin
        repeat (2) @(negedge clk);
        chk("R9", "valid held", {31'b0, mem_req_valid}, 32'd1);
        chk("R9", "addr held", mem_req_addr, 32'h1000);
        repeat (3) @(negedge clk);
        chk("R9", "addr still held", mem_req_addr, 32'h1000);
        stall_mem = 1'b0;
      end
    join
    chk("R9", "paddr after stall", w_pa, 32'hABCD_E123);

    // R7: request during a walk is ignored
    r0 = resp_cnt;
    fork
      run_walk(32'h003F_FFFF);
      begin
        repeat (3) @(negedge clk);
        req_valid = 1'b1;
        req_vaddr = 32'h0140_0456;
        repeat (2) @(negedge clk);
        req_valid = 1'b0;
      end
    join
    repeat (6) @(negedge clk);
    chk("R7", "busy request result", w_pa, 32'h1234_5FFF);
    chk("R7", "one response only", resp_cnt - r0, 32'd1);
    chk("R7", "two reads only", rd_cnt - w_first, 32'd2);

    // R8: root write during a walk ignored
    fork
      run_walk(32'h0000_0123);
      begin
        repeat (3) @(negedge clk);
        root_we   = 1'b1;
        root_page = 20'h00003;
        @(negedge clk);
        root_we = 1'b0;
      end
    join
    run_walk(32'h0000_0123);
    chk("R8", "busy write ignored", rd_log[w_first[5:0]], 32'h1000);
    chk("R8", "result unchanged", w_pa, 32'hABCD_E123);

    // R8: root write while idle takes effect
    set_root(20'h00003);
    p0 = 0;
    run_walk(32'h8000_0000);
    chk("R8", "idle write used", rd_log[w_first[5:0]], 32'h3800);
    chk("R5", "fault beyond memory", {30'b0, w_fault, w_lvl}, 32'd3);
    set_root(20'h00001);
    run_walk(32'hFFE0_0000);
    chk("R6", "restored root paddr", w_pa + p0, 32'hFFFF_F000);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule